// File: doc/BRIEF.md
# Counting Response Compactor

This block reduces a serial stream of response bits from a circuit under test to one small value and judges it against a known-good reference at the end of the run. Three lossy reductions share a single datapath: a running parity bit, a count of ones, and a count of level changes between successive bits. The transition count keeps the last accepted bit in a register.

A test run starts with a start/clear pulse and a chosen mode. Response bits are accepted on cycles where the valid strobe is high. An end-of-test pulse then latches a registered verdict. The verdict shows pass when the accumulated value equals the reference and fail when it does not. Stimulus generation and the derivation of reference values happen elsewhere.

Top module: `resp_compactor`

## Requirements
- R1: After reset, and one clock after a start/clear pulse, the count, the parity bit and the previous-bit register are zero, and verdictValid, passOut and failOut are all low. Start/clear takes priority over every other input in the same cycle.
- R2: With modeSel = 2'b00 (parity), the block keeps the XOR of all accepted bits. The verdict compares that single bit with bit 0 of refValue.
- R3: With modeSel = 2'b01 (ones counting), the count rises by one for every accepted bit equal to 1.
- R4: With modeSel = 2'b10 or 2'b11 (transition counting), the count rises by one for every accepted bit that differs from the previously accepted bit. Because the previous bit starts at 0, a leading 1 counts as a transition.
- R5: A bit is accepted only on a rising clock edge where bitValid is high. respBit has no effect on any other cycle.
- R6: The count is CNT_W bits wide. It saturates at 2**CNT_W-1 instead of wrapping.
- R7: endTest, sampled at a clock edge, makes verdictValid high from that edge onward. passOut is set when the value accumulated before that edge matches the reference, and failOut is set otherwise. While verdictValid is high, exactly one of passOut and failOut is high.
- R8: Once latched, the verdict stays unchanged until the next start/clear or endTest, even if more bits are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startClr | input | 1 | Start of run; clears accumulated state and verdict |
| bitValid | input | 1 | Qualifies respBit on this cycle |
| respBit | input | 1 | Serial response bit |
| modeSel | input | 2 | 00 parity, 01 ones count, 1x transition count |
| refValue | input | CNT_W | Fault-free reference value |
| endTest | input | 1 | Ends the run and latches the verdict |
| verdictValid | output | 1 | Verdict outputs are meaningful |
| passOut | output | 1 | Accumulated value matched the reference |
| failOut | output | 1 | Accumulated value differed from the reference |

## Verification
The properties assume that modeSel stays constant between a start/clear and the following endTest. They also assume that refValue is steady on the cycle endTest is sampled. The stimulus changes the mode only together with start/clear, and it holds refValue from before the end pulse until the verdict is seen. The bench never raises bitValid and endTest on the same cycle, so every expected verdict covers exactly the bits the bench model has taken in.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    MODE_PARITY = 2'b00,
    MODE_ONES   = 2'b01,
    MODE_TRANS  = 2'b10,
    MODE_TRANS2 = 2'b11
  } mode_e;

  typedef struct packed {
    logic clrAll;
    logic accEn;
    logic evalEn;
  } ctrl_s;
endpackage

// File: rtl/rc_ctrl.sv
module rc_ctrl
  import rc_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  startClr,
  input  logic  bitValid,
  input  logic  endTest,
  input  logic  matchIn,
  output ctrl_s ctrl,
  output logic  verdictValid,
  output logic  passOut,
  output logic  failOut
);
  // start/clear dominates accumulation and evaluation
  always_comb begin
    ctrl.clrAll = startClr;
    ctrl.accEn  = bitValid & ~startClr;
    ctrl.evalEn = endTest & ~startClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      verdictValid <= 1'b0;
      passOut      <= 1'b0;
      failOut      <= 1'b0;
    end else if (ctrl.clrAll) begin
      verdictValid <= 1'b0;
      passOut      <= 1'b0;
      failOut      <= 1'b0;
    end else if (ctrl.evalEn) begin
      verdictValid <= 1'b1;
      passOut      <= matchIn;
      failOut      <= ~matchIn;
    end
  end
endmodule

// File: rtl/rc_datapath.sv
module rc_datapath
  import rc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_s            ctrl,
  input  logic             respBit,
  input  logic [1:0]       modeSel,
  input  logic [CNT_W-1:0] refValue,
  output logic             matchOut,
  output logic [CNT_W-1:0] accCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  mode_e            mode;
  logic             parityQ;
  logic             prevQ;
  logic [CNT_W-1:0] cntQ;
  logic             bump;

  assign mode = mode_e'(modeSel);

  always_comb begin
    unique case (mode)
      MODE_ONES:               bump = respBit;
      MODE_TRANS, MODE_TRANS2: bump = respBit ^ prevQ;
      default:                 bump = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parityQ <= 1'b0;
      prevQ   <= 1'b0;
      cntQ    <= '0;
    end else if (ctrl.clrAll) begin
      parityQ <= 1'b0;
      prevQ   <= 1'b0;
      cntQ    <= '0;
    end else if (ctrl.accEn) begin
      parityQ <= parityQ ^ respBit;
      prevQ   <= respBit;
      if (bump && (cntQ != CNT_MAX)) cntQ <= cntQ + 1'b1;
    end
  end

  always_comb begin
    if (mode == MODE_PARITY) matchOut = (parityQ == refValue[0]);
    else                     matchOut = (cntQ == refValue);
  end

  assign accCount = cntQ;
endmodule

// File: rtl/resp_compactor.sv
module resp_compactor
  import rc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startClr,
  input  logic             bitValid,
  input  logic             respBit,
  input  logic [1:0]       modeSel,
  input  logic [CNT_W-1:0] refValue,
  input  logic             endTest,
  output logic             verdictValid,
  output logic             passOut,
  output logic             failOut
);
  ctrl_s            ctrl;
  logic             match;
  logic [CNT_W-1:0] accCount;

  rc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startClr(startClr), .bitValid(bitValid),
    .endTest(endTest), .matchIn(match), .ctrl(ctrl),
    .verdictValid(verdictValid), .passOut(passOut), .failOut(failOut)
  );

  rc_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .respBit(respBit),
    .modeSel(modeSel), .refValue(refValue), .matchOut(match),
    .accCount(accCount)
  );
endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             startClr,
  input logic             bitValid,
  input logic             endTest,
  input logic             verdictValid,
  input logic             passOut,
  input logic             failOut,
  input logic [CNT_W-1:0] accCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r1_clear: assert property (@(posedge clk) disable iff (!rstN)
    startClr |=> (!verdictValid && accCount == '0));

  a_r1_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !verdictValid |-> !(passOut || failOut));

  a_r5_no_accept: assert property (@(posedge clk) disable iff (!rstN)
    (!bitValid && !startClr) |=> $stable(accCount));

  a_r6_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (accCount == CNT_MAX && !startClr) |=> accCount == CNT_MAX);

  a_r7_latch: assert property (@(posedge clk) disable iff (!rstN)
    (endTest && !startClr) |=> verdictValid);

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid |-> (passOut ^ failOut));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!startClr && !endTest) |=> $stable({verdictValid, passOut, failOut}));
endmodule

bind resp_compactor rc_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .startClr(startClr), .bitValid(bitValid),
  .endTest(endTest), .verdictValid(verdictValid), .passOut(passOut),
  .failOut(failOut), .accCount(accCount)
);

// File: tb/resp_compactor_tb_top.sv
module resp_compactor_tb_top;
  localparam int CNT_W = 8;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startClr = 1'b0, bitValid = 1'b0, respBit = 1'b0, endTest = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic [CNT_W-1:0] refValue = '0;
  logic verdictValid, passOut, failOut;

  int total = 0, bad = 0;
  int mCnt = 0;
  bit mPar = 0, mPrev = 0;
  bit expQ[$];
  string tagQ[$];
  logic lastV = 1'b0;

  always #4 clk = ~clk;

  resp_compactor #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .startClr(startClr), .bitValid(bitValid),
    .respBit(respBit), .modeSel(modeSel), .refValue(refValue),
    .endTest(endTest), .verdictValid(verdictValid), .passOut(passOut),
    .failOut(failOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected verdict when verdictValid rises
  always @(negedge clk) begin
    if (verdictValid && !lastV) begin
      if (expQ.size() == 0) check("R7 unexpected verdict", 1, 0);
      else begin
        bit e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({t, " pass"}, passOut, e);
        check({t, " fail"}, failOut, !e);
      end
    end
    lastV = verdictValid;
  end

  task automatic startRun(input logic [1:0] m);
    @(negedge clk);
    startClr = 1'b1; modeSel = m; bitValid = 1'b0;
    @(negedge clk);
    startClr = 1'b0;
    check("R1 cleared verdictValid", verdictValid, 0);
    check("R1 cleared pass/fail", {passOut, failOut}, 0);
    mCnt = 0; mPar = 0; mPrev = 0;
  endtask

  task automatic feedBit(input bit b, input bit v);
    respBit = b; bitValid = v;
    @(negedge clk);
    bitValid = 1'b0;
    if (v) begin
      bit inc;
      mPar ^= b;
      if (modeSel == 2'b01) inc = b;
      else if (modeSel[1])  inc = b ^ mPrev;
      else                  inc = 0;
      mPrev = b;
      if (inc && mCnt < MAXV) mCnt++;
    end
  endtask

  task automatic feedWord(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) feedBit(w[i], 1'b1);
  endtask

  task automatic endRun(input logic [CNT_W-1:0] r, input string tag);
    bit e;
    refValue = r;
    e = (modeSel == 2'b00) ? (mPar == r[0]) : (mCnt == int'(r));
    expQ.push_back(e);
    tagQ.push_back(tag);
    check({tag, " R7 no verdict before end"}, verdictValid, 0);
    endTest = 1'b1;
    @(posedge clk);
    #1;
    check({tag, " R7 verdict one edge after end"}, verdictValid, 1);
    @(negedge clk);
    endTest = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    check("watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset verdict", {verdictValid, passOut, failOut}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 ones counting: 11101010 has five ones
    startRun(2'b01); feedWord(32'hEA, 8); endRun(8'd5, "R3 ones=5");
    startRun(2'b01); feedWord(32'hEA, 8); endRun(8'd8, "R3 ones vs 8");
    startRun(2'b01); feedWord(32'h0, 16); endRun(8'd0, "R3 all zero");

    // R2 parity
    startRun(2'b00); feedWord(32'hEA, 8); endRun(8'd1, "R2 parity odd");
    startRun(2'b00); feedWord(32'hEA, 8); endRun(8'd0, "R2 parity mismatch");
    startRun(2'b00); feedWord(32'hC3, 8); endRun(8'hFE, "R2 only bit0 used");

    // R4 transitions, leading 1 counts
    startRun(2'b10); feedBit(1, 1); endRun(8'd1, "R4 leading one");
    startRun(2'b10); feedWord(32'h6, 4); endRun(8'd2, "R4 0110");
    startRun(2'b11); feedWord(32'hAAAA, 16); endRun(8'd16, "R4 alt code");
    startRun(2'b10); feedWord(32'hF0, 8); endRun(8'd3, "R4 wrong ref");

    // R5 bits without valid ignored
    startRun(2'b01);
    feedBit(1, 1); feedBit(1, 0); feedBit(1, 0); feedBit(1, 1);
    endRun(8'd2, "R5 gated ones");
    startRun(2'b10);
    feedBit(1, 0); feedBit(0, 1); feedBit(1, 0);
    endRun(8'd0, "R5 gated transitions");

    // R6 saturation
    startRun(2'b01);
    for (int i = 0; i < 300; i++) feedBit(1, 1);
    endRun(8'd255, "R6 saturated");
    startRun(2'b01);
    for (int i = 0; i < 300; i++) feedBit(1, 1);
    endRun(8'd44, "R6 no wrap");

    // R8 verdict holds while more bits arrive
    startRun(2'b01); feedWord(32'h7, 3); endRun(8'd3, "R8 base");
    feedWord(32'hFF, 8);
    check("R8 held pass", {verdictValid, passOut, failOut}, 3'b110);

    // R1 start/clear wipes a latched verdict
    @(negedge clk); startClr = 1'b1;
    @(negedge clk); startClr = 1'b0;
    check("R1 clear after verdict", {verdictValid, passOut, failOut}, 0);

    repeat (3) @(negedge clk);
    check("R7 all verdicts seen", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule